// File: doc/BRIEF.md
# Three-Channel Timer Register Front End

This block is the software-visible register file for a group of three timer channels. A single 32-bit bus with a word index, a write strobe, a read strobe, write data and registered read data reaches every register of all three channels. The copies of one register for the three channels sit in three adjacent words. The channel is therefore the word index modulo 3, and the register group is the word index divided by 3. Each channel's writable settings are presented on output ports, so that the channel's counting core can use them.

The counting cores themselves sit outside this block. Each core returns a 16-bit count, a 16-bit event count and six event flags. The flags collect in a per-channel sticky status register, which is cleared by reading it. Each channel drives one interrupt line, which is high while any status bit that is also enabled is set. Writing a channel's counter control with the clear bit set produces a one-cycle clear pulse for that channel's core.

Top module: `tri_timer_regs`

## Requirements
- R1: A bus word index w (byte offset 4*w) addresses register group w/3 of channel w%3. The groups are: 0 clock control, 1 counter control, 2 counter value, 3 interval, 4/5/6 match A/B/C, 7 status, 8 interrupt enable, 9 event control, 10 event count. Writes and reads reach only the addressed channel.
- R2: Writes keep only bits [5:0] for clock control and interrupt enable, bits [15:0] for interval and the three match registers, and bits [2:0] for event control. The remaining bits read as zero.
- R3: Counter control stores bits [5:0] with bit 4 forced to zero, so bit 4 always reads zero. A write to it with bit 4 set drives `count_clr[ch]` high for exactly the one cycle after the write.
- R4: After a synchronous active-low reset, counter control of every channel is 0x21 and every other register, `bus_rdata`, `count_clr` and `irq` are zero.
- R5: A high bit of a channel's six event flags in a cycle sets the matching status bit, which then stays set until it is read.
- R6: A read of a status register returns its contents and clears the returned bits in the same access. An event flag arriving in the cycle of that read stays set.
- R7: Writes to the status, counter value and event count groups change nothing.
- R8: Reads of counter value and event count return the channel's 16-bit input, sampled in the read cycle and zero-extended to 32 bits.
- R9: Word indices 33 and above are unmapped. Reads of them return zero and writes to them change nothing.
- R10: `bus_rdata` is registered: it shows the read value in the cycle after `bus_rd` and holds it while no read is made. A read that coincides with a write returns the old contents.
- R11: `irq[ch]` is high exactly when the channel's status AND its interrupt enable is non-zero. It therefore rises in the cycle after the causing flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_word | input | 6 | Word index (byte offset / 4) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ch_count | input | 48 | Per-channel 16-bit count, channel c at [16c+15:16c] |
| ch_evt_count | input | 48 | Per-channel 16-bit event count |
| ch_flags | input | 18 | Per-channel six event flags, channel c at [6c+5:6c] |
| clk_ctrl | output | 18 | Per-channel clock control |
| cnt_ctrl | output | 18 | Per-channel counter control |
| interval | output | 48 | Per-channel interval value |
| match | output | 144 | Match value k of channel c at [16(3c+k)+15:16(3c+k)] |
| irq_en | output | 18 | Per-channel interrupt enable |
| evt_ctrl | output | 9 | Per-channel event control |
| count_clr | output | 3 | One-cycle count clear pulse per channel |
| irq | output | 3 | Per-channel interrupt line |

## Verification
Most state in this block is mirrored on the per-channel output ports. A wrong channel or group decode therefore shows on the next clock as a changed value in the wrong channel's slice, and the bench compares every slice on every cycle. The status register is visible only through `irq` and reads. A lost or stale status bit shows as a wrong `irq` level one cycle after the flag, or as a wrong value one cycle after the read that clears it. The same-cycle case of a flag arriving during a read is driven directly.

// File: rtl/tri_timer_pkg.sv
// Shared widths, reset values and the register group encoding for the
// three-channel timer register front end. The group order is fixed by the
// address layout: group number = word index / 3.
package tri_timer_pkg;
    localparam int CH_N      = 3;
    localparam int NUM_MATCH = 3;
    localparam int DATA_W    = 32;
    localparam int CTRL_W    = 6;
    localparam int VAL_W     = 16;
    localparam int ECTL_W    = 3;
    localparam int FLAG_W    = 6;
    localparam int GRP_N     = 11;
    localparam int CLR_BIT   = 4;
    localparam logic [CTRL_W-1:0] CNT_CTRL_INIT = 6'h21;

    typedef enum logic [3:0] {
        GRP_CLK  = 4'd0,
        GRP_CNT  = 4'd1,
        GRP_VAL  = 4'd2,
        GRP_INTV = 4'd3,
        GRP_MA   = 4'd4,
        GRP_MB   = 4'd5,
        GRP_MC   = 4'd6,
        GRP_STAT = 4'd7,
        GRP_IEN  = 4'd8,
        GRP_ECTL = 4'd9,
        GRP_ECNT = 4'd10,
        GRP_NONE = 4'd15
    } grp_e;

    typedef struct packed {
        logic       hit;
        grp_e       grp;
        logic [1:0] chan;
    } dec_t;
endpackage

// File: rtl/tri_timer_decode.sv
// Address decoder: splits a word index into register group (index / 3) and
// channel (index % 3). Assumes WORD_W is at least 6 so all 33 words fit.
module tri_timer_decode import tri_timer_pkg::*; #(
    parameter int WORD_W = 6
) (
    input  logic [WORD_W-1:0] word_i,
    output dec_t              dec_o
);
    logic [WORD_W-1:0] grp_num;

    // Purpose: divide the word index into group and channel fields.
    always_comb begin
        grp_num    = word_i / WORD_W'(3);
        dec_o.hit  = (grp_num < WORD_W'(GRP_N));
        dec_o.grp  = dec_o.hit ? grp_e'(4'(grp_num)) : GRP_NONE;
        dec_o.chan = 2'(word_i % WORD_W'(3));
        assert_chan_range_R1: assert (dec_o.chan != 2'd3);
    end
endmodule

// File: rtl/tri_timer_chan.sv
// One channel's register bank: writable settings with masks, the sticky
// clear-on-read status register, the count clear pulse, the interrupt line
// and the combinational read value for the currently decoded group.
// Assumes sel_i is high only when this channel is addressed by a mapped word.
module tri_timer_chan import tri_timer_pkg::*; (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sel_i,
    input  logic                       wr_i,
    input  logic                       rd_i,
    input  grp_e                       grp_i,
    input  logic [DATA_W-1:0]          wdata_i,
    input  logic [VAL_W-1:0]           count_i,
    input  logic [VAL_W-1:0]           evt_i,
    input  logic [FLAG_W-1:0]          flag_i,
    output logic [CTRL_W-1:0]          clk_ctrl_o,
    output logic [CTRL_W-1:0]          cnt_ctrl_o,
    output logic [VAL_W-1:0]           intv_o,
    output logic [NUM_MATCH*VAL_W-1:0] match_o,
    output logic [FLAG_W-1:0]          ien_o,
    output logic [ECTL_W-1:0]          ectl_o,
    output logic                       clr_o,
    output logic                       irq_o,
    output logic [DATA_W-1:0]          rd_val_o
);
    logic                wr_hit;
    logic                rd_stat;
    logic [CTRL_W-1:0]   clk_q;
    logic [CTRL_W-1:0]   cnt_q;
    logic [VAL_W-1:0]    intv_q;
    logic [VAL_W-1:0]    match_q [NUM_MATCH];
    logic [FLAG_W-1:0]   stat_q;
    logic [FLAG_W-1:0]   ien_q;
    logic [ECTL_W-1:0]   ectl_q;
    logic                clr_q;

    assign wr_hit  = sel_i && wr_i;
    assign rd_stat = sel_i && rd_i && (grp_i == GRP_STAT);

    // Purpose: hold the masked control settings written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q  <= '0;
            cnt_q  <= CNT_CTRL_INIT;
            intv_q <= '0;
            ien_q  <= '0;
            ectl_q <= '0;
        end else if (wr_hit) begin
            case (grp_i)
                GRP_CLK:  clk_q  <= wdata_i[CTRL_W-1:0];
                GRP_CNT:  begin
                    cnt_q          <= wdata_i[CTRL_W-1:0];
                    cnt_q[CLR_BIT] <= 1'b0;
                end
                GRP_INTV: intv_q <= wdata_i[VAL_W-1:0];
                GRP_IEN:  ien_q  <= wdata_i[FLAG_W-1:0];
                GRP_ECTL: ectl_q <= wdata_i[ECTL_W-1:0];
                default:  ;
            endcase
        end
    end

    // One register per match value, selected by consecutive groups.
    for (genvar m = 0; m < NUM_MATCH; m++) begin : g_match
        // Purpose: hold match value m.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                match_q[m] <= '0;
            end else if (wr_hit && (4'(grp_i) == 4'(int'(GRP_MA) + m))) begin
                match_q[m] <= wdata_i[VAL_W-1:0];
            end
        end
        assign match_o[m*VAL_W +: VAL_W] = match_q[m];
    end

    // Purpose: collect event flags; a status read clears what it returned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (rd_stat ? '0 : stat_q) | flag_i;
        end
    end

    // Purpose: one-cycle count clear request after a counter control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_q <= 1'b0;
        end else begin
            clr_q <= wr_hit && (grp_i == GRP_CNT) && wdata_i[CLR_BIT];
        end
    end

    // Purpose: zero-extended read value of the decoded group.
    always_comb begin
        case (grp_i)
            GRP_CLK:  rd_val_o = DATA_W'(clk_q);
            GRP_CNT:  rd_val_o = DATA_W'(cnt_q);
            GRP_VAL:  rd_val_o = DATA_W'(count_i);
            GRP_INTV: rd_val_o = DATA_W'(intv_q);
            GRP_MA:   rd_val_o = DATA_W'(match_q[0]);
            GRP_MB:   rd_val_o = DATA_W'(match_q[1]);
            GRP_MC:   rd_val_o = DATA_W'(match_q[2]);
            GRP_STAT: rd_val_o = DATA_W'(stat_q);
            GRP_IEN:  rd_val_o = DATA_W'(ien_q);
            GRP_ECTL: rd_val_o = DATA_W'(ectl_q);
            GRP_ECNT: rd_val_o = DATA_W'(evt_i);
            default:  rd_val_o = '0;
        endcase
    end

    assign clk_ctrl_o = clk_q;
    assign cnt_ctrl_o = cnt_q;
    assign intv_o     = intv_q;
    assign ien_o      = ien_q;
    assign ectl_o     = ectl_q;
    assign clr_o      = clr_q;
    assign irq_o      = |(stat_q & ien_q);

    assert_clr_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |-> $past(wr_hit && (grp_i == GRP_CNT) && wdata_i[CLR_BIT]));

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_i != '0) |=> ((stat_q & $past(flag_i)) == $past(flag_i)));

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && (flag_i == '0)) |=> (stat_q == '0));

    assert_stat_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && (grp_i == GRP_STAT) && !rd_stat && (flag_i == '0)) |=> $stable(stat_q));

    assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_o == '0) |-> !irq_o);
endmodule

// File: rtl/tri_timer_regs.sv
// Top of the three-channel timer register front end. Decodes the word index,
// fans the bus out to three channel banks and registers the read data.
// Assumes at most one of the channel banks is selected per access.
module tri_timer_regs import tri_timer_pkg::*; #(
    parameter int WORD_W = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [WORD_W-1:0]               bus_word,
    input  logic                            bus_wr,
    input  logic                            bus_rd,
    input  logic [DATA_W-1:0]               bus_wdata,
    output logic [DATA_W-1:0]               bus_rdata,
    input  logic [CH_N*VAL_W-1:0]           ch_count,
    input  logic [CH_N*VAL_W-1:0]           ch_evt_count,
    input  logic [CH_N*FLAG_W-1:0]          ch_flags,
    output logic [CH_N*CTRL_W-1:0]          clk_ctrl,
    output logic [CH_N*CTRL_W-1:0]          cnt_ctrl,
    output logic [CH_N*VAL_W-1:0]           interval,
    output logic [CH_N*NUM_MATCH*VAL_W-1:0] match,
    output logic [CH_N*FLAG_W-1:0]          irq_en,
    output logic [CH_N*ECTL_W-1:0]          evt_ctrl,
    output logic [CH_N-1:0]                 count_clr,
    output logic [CH_N-1:0]                 irq
);
    localparam int MATCH_W = NUM_MATCH * VAL_W;

    dec_t              dec;
    logic [DATA_W-1:0] rd_vals [CH_N];
    logic [DATA_W-1:0] sel_val;
    logic [DATA_W-1:0] rdata_q;

    tri_timer_decode #(.WORD_W(WORD_W)) i_decode (
        .word_i (bus_word),
        .dec_o  (dec)
    );

    // One register bank per channel.
    for (genvar c = 0; c < CH_N; c++) begin : g_chan
        tri_timer_chan i_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel_i      (dec.hit && (dec.chan == 2'(c))),
            .wr_i       (bus_wr),
            .rd_i       (bus_rd),
            .grp_i      (dec.grp),
            .wdata_i    (bus_wdata),
            .count_i    (ch_count[c*VAL_W +: VAL_W]),
            .evt_i      (ch_evt_count[c*VAL_W +: VAL_W]),
            .flag_i     (ch_flags[c*FLAG_W +: FLAG_W]),
            .clk_ctrl_o (clk_ctrl[c*CTRL_W +: CTRL_W]),
            .cnt_ctrl_o (cnt_ctrl[c*CTRL_W +: CTRL_W]),
            .intv_o     (interval[c*VAL_W +: VAL_W]),
            .match_o    (match[c*MATCH_W +: MATCH_W]),
            .ien_o      (irq_en[c*FLAG_W +: FLAG_W]),
            .ectl_o     (evt_ctrl[c*ECTL_W +: ECTL_W]),
            .clr_o      (count_clr[c]),
            .irq_o      (irq[c]),
            .rd_val_o   (rd_vals[c])
        );
    end

    // Purpose: pick the addressed channel's read value.
    always_comb begin
        sel_val = '0;
        for (int i = 0; i < CH_N; i++) begin
            if (dec.chan == 2'(i)) sel_val = rd_vals[i];
        end
    end

    // Purpose: register read data; hold it between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= dec.hit ? sel_val : '0;
        end
    end

    assign bus_rdata = rdata_q;

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !dec.hit) |=> (bus_rdata == '0));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/test_tri_timer_regs.sv
module test_tri_timer_regs;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [5:0]   bus_word = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [47:0]  ch_count = '0;
    logic [47:0]  ch_evt_count = '0;
    logic [17:0]  ch_flags = '0;
    logic [17:0]  clk_ctrl, cnt_ctrl, irq_en;
    logic [47:0]  interval;
    logic [143:0] match;
    logic [8:0]   evt_ctrl;
    logic [2:0]   count_clr, irq;

    tri_timer_regs i_tri_timer_regs (
        .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_count(ch_count), .ch_evt_count(ch_evt_count), .ch_flags(ch_flags),
        .clk_ctrl(clk_ctrl), .cnt_ctrl(cnt_ctrl), .interval(interval),
        .match(match), .irq_en(irq_en), .evt_ctrl(evt_ctrl),
        .count_clr(count_clr), .irq(irq)
    );

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Reference model state, updated at every rising edge.
    int m_clk [3], m_cnt [3], m_intv [3], m_stat [3], m_ien [3], m_ectl [3];
    int m_match [3][3];
    logic [31:0] m_rdata;
    logic [2:0]  m_clr;
    string rd_tag = "R10";
    bit model_valid = 0;

    function automatic logic [31:0] ref_read(input int g, input int c);
        case (g)
            0: return 32'(m_clk[c]);
            1: return 32'(m_cnt[c]);
            2: return 32'(ch_count[c*16 +: 16]);
            3: return 32'(m_intv[c]);
            4, 5, 6: return 32'(m_match[c][g-4]);
            7: return 32'(m_stat[c]);
            8: return 32'(m_ien[c]);
            9: return 32'(m_ectl[c]);
            10: return 32'(ch_evt_count[c*16 +: 16]);
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        int w, c, g;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_clk[i] = 0; m_cnt[i] = 'h21; m_intv[i] = 0; m_stat[i] = 0;
                m_ien[i] = 0; m_ectl[i] = 0;
                for (int k = 0; k < 3; k++) m_match[i][k] = 0;
            end
            m_rdata = 0;
            m_clr = 0;
        end else begin
            w = int'(bus_word); c = w % 3; g = w / 3;
            if (bus_rd) begin
                m_rdata = ref_read(g, c);
                rd_tag = (g == 7) ? "R6" : (g == 2 || g == 10) ? "R8" : (g > 10) ? "R9" : "R10";
            end
            m_clr = 0;
            if (bus_wr) begin
                case (g)
                    0: m_clk[c] = int'(bus_wdata & 32'h3F);
                    1: begin
                        m_cnt[c] = int'(bus_wdata & 32'h2F);
                        if (bus_wdata[4]) m_clr[c] = 1'b1;
                    end
                    3: m_intv[c] = int'(bus_wdata & 32'hFFFF);
                    4, 5, 6: m_match[c][g-4] = int'(bus_wdata & 32'hFFFF);
                    8: m_ien[c] = int'(bus_wdata & 32'h3F);
                    9: m_ectl[c] = int'(bus_wdata & 32'h7);
                    default: ;
                endcase
            end
            for (int i = 0; i < 3; i++) begin
                m_stat[i] = ((bus_rd && g == 7 && c == i) ? 0 : m_stat[i]) | int'(ch_flags[i*6 +: 6]);
            end
        end
        model_valid = 1;
    end

    // Compare every port with the model, away from the rising edge.
    always @(negedge clk) begin
        if (model_valid && !done) begin
            chk(rst_n ? rd_tag : "R4", "rdata", bus_rdata, m_rdata);
            for (int i = 0; i < 3; i++) begin
                chk(rst_n ? "R2" : "R4", "clk_ctrl", 32'(clk_ctrl[i*6 +: 6]), 32'(m_clk[i]));
                chk(rst_n ? "R3" : "R4", "cnt_ctrl", 32'(cnt_ctrl[i*6 +: 6]), 32'(m_cnt[i]));
                chk(rst_n ? "R2" : "R4", "interval", 32'(interval[i*16 +: 16]), 32'(m_intv[i]));
                for (int k = 0; k < 3; k++)
                    chk(rst_n ? "R2" : "R4", "match", 32'(match[(i*3+k)*16 +: 16]), 32'(m_match[i][k]));
                chk(rst_n ? "R2" : "R4", "irq_en", 32'(irq_en[i*6 +: 6]), 32'(m_ien[i]));
                chk(rst_n ? "R2" : "R4", "evt_ctrl", 32'(evt_ctrl[i*3 +: 3]), 32'(m_ectl[i]));
                chk(rst_n ? "R3" : "R4", "count_clr", 32'(count_clr[i]), 32'(m_clr[i]));
                chk(rst_n ? "R11" : "R4", "irq", 32'(irq[i]), 32'((m_stat[i] & m_ien[i]) != 0));
            end
        end
    end

    task automatic op(input logic w, input logic r, input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_word = a; bus_wdata = d;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        op(1'b0, 1'b1, a, 32'h0);
        op(1'b0, 1'b0, 6'd0, 32'h0);
        v = bus_rdata;
    endtask

    task automatic flag_pulse(input logic [17:0] f);
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; ch_flags = f;
        @(negedge clk);
        ch_flags = '0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 60000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<60000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R4: reset state
        chk("R4", "irq after reset", 32'(irq), 32'h0);
        rd(6'd3, v);  chk("R4", "cnt ctrl ch0 reset", v, 32'h21);
        rd(6'd21, v); chk("R4", "status ch0 reset", v, 32'h0);
        // R1, R2: layout and masks
        op(1, 0, 6'd1, 32'hFFFF_FFEA);
        rd(6'd1, v);  chk("R1", "clk ctrl ch1", v, 32'h2A);
        chk("R1", "clk ctrl ch1 port", 32'(clk_ctrl[11:6]), 32'h2A);
        chk("R1", "clk ctrl ch0 untouched", 32'(clk_ctrl[5:0]), 32'h0);
        op(1, 0, 6'd10, 32'h1234_5678);
        rd(6'd10, v); chk("R2", "interval ch1", v, 32'h5678);
        chk("R1", "interval ch0 untouched", 32'(interval[15:0]), 32'h0);
        op(1, 0, 6'd17, 32'hCAFE_BABE);
        rd(6'd17, v); chk("R2", "match B ch2", v, 32'hBABE);
        chk("R1", "match B ch2 port", 32'(match[127:112]), 32'hBABE);
        op(1, 0, 6'd27, 32'hFF);
        rd(6'd27, v); chk("R2", "evt ctrl ch0", v, 32'h7);
        op(1, 0, 6'd25, 32'hFFFF);
        rd(6'd25, v); chk("R2", "irq en ch1", v, 32'h3F);
        // R3: clear bit
        op(1, 0, 6'd4, 32'h3F);
        op(0, 0, 6'd0, 32'h0);
        chk("R3", "clear pulse", 32'(count_clr), 32'h2);
        op(0, 0, 6'd0, 32'h0);
        chk("R3", "clear pulse ends", 32'(count_clr), 32'h0);
        rd(6'd4, v);  chk("R3", "cnt ctrl bit4 reads zero", v, 32'h2F);
        // R8: live counts
        ch_count[47:32] = 16'hBEEF;
        ch_evt_count[15:0] = 16'h1357;
        rd(6'd8, v);  chk("R8", "count ch2", v, 32'h0000_BEEF);
        rd(6'd30, v); chk("R8", "evt count ch0", v, 32'h0000_1357);
        // R7: read-only groups
        op(1, 0, 6'd8, 32'hFFFF);
        rd(6'd8, v);  chk("R7", "count write ignored", v, 32'hBEEF);
        op(1, 0, 6'd22, 32'h3F);
        rd(6'd22, v); chk("R7", "status write ignored", v, 32'h0);
        op(1, 0, 6'd30, 32'h0);
        rd(6'd30, v); chk("R7", "evt count write ignored", v, 32'h1357);
        // R9: unmapped
        op(1, 0, 6'd40, 32'hFFFF_FFFF);
        rd(6'd40, v); chk("R9", "unmapped 40", v, 32'h0);
        rd(6'd63, v); chk("R9", "unmapped 63", v, 32'h0);
        // R5, R11: flags and interrupts
        flag_pulse(18'h04 << 6);
        chk("R11", "irq ch1 raised", 32'(irq), 32'h2);
        flag_pulse(18'h01);
        chk("R11", "irq ch0 masked", 32'(irq), 32'h2);
        rd(6'd21, v); chk("R5", "status ch0 sticky", v, 32'h01);
        rd(6'd22, v); chk("R6", "status ch1 read", v, 32'h04);
        chk("R6", "irq drops after read", 32'(irq), 32'h0);
        // R6: flag in the same cycle as the clearing read
        flag_pulse(18'h01 << 6);
        @(negedge clk);
        bus_rd = 1; bus_word = 6'd22; ch_flags = 18'h20 << 6;
        @(negedge clk);
        bus_rd = 0; ch_flags = '0;
        chk("R6", "read returns old bits", bus_rdata, 32'h01);
        chk("R6", "new flag keeps irq", 32'(irq), 32'h2);
        rd(6'd22, v); chk("R6", "new flag kept", v, 32'h20);
        // R10: read data held between reads
        rd(6'd10, v); chk("R10", "read value", v, 32'h5678);
        op(1, 0, 6'd9, 32'h1);
        op(0, 0, 6'd0, 32'h0);
        chk("R10", "rdata held", bus_rdata, 32'h5678);
        // Random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            bus_word  = 6'($urandom % 64);
            bus_wr    = ($urandom % 3) == 0;
            bus_rd    = ($urandom % 2) == 0;
            bus_wdata = $urandom;
            ch_count  = {$urandom, $urandom};
            ch_evt_count = {$urandom, $urandom};
            ch_flags  = (($urandom % 6) == 0) ? 18'($urandom) : 18'h0;
        end
        op(0, 0, 6'd0, 32'h0);
        ch_flags = '0;
        @(negedge clk);
        finish_run();
    end
endmodule